// File: doc/BRIEF.md
# Secure Region Authentication Controller

This block governs when a small processor core enters and leaves an authenticated execution mode. It keeps a flag table with one entry per 256-byte page. Each entry holds a secret flag, written by software, and a valid flag, owned by the controller. Every instruction fetch is compared against this table. When the core runs in non-secure mode and fetches from a page flagged secret, the controller raises a secret fault and stalls the core.

It then asks an external MAC engine to check the region described by its region register. The engine compares the result against the reference MAC held in crypto register 6. If the MAC matches, the controller:
- marks every page of the region valid;
- loads the program counter with the region base;
- enters secure mode;
- sets the saved-signature flag;
- records that sequence slot 0 holds a three-step macro.

If the MAC does not match, the core is halted for good. When a secure-mode fetch lands on a page that is not secret, the controller drops back to non-secure mode and withdraws the valid flag from every secret page.

The MAC datapath and the instruction decoder sit outside this block. The MAC engine is reached through a level request that is held until a one-cycle done pulse arrives, qualified by a match bit.

Top module: `sec_auth_ctrl`

## Requirements
- R1: After reset the core is non-secure, not halted and not stalled, no MAC request is raised, the signature flag and sequence-slot length are 0, and every page's secret and valid flags read 0.
- R2: The region register is 32 bits wide:
  - bits 7:0 give the start page, so `mac_addr_o` is start×256;
  - bits 31:24 give the page count, so `mac_len_o` is count×256;
  - bits 16 and 17 are exported on `region_xfer_o` and `region_enc_o` and affect nothing else;
  - all other bits are ignored.
- R3: A fetch in non-secure idle state from a page whose secret flag is 1 (page = address bits 15:8) raises `stall_o` in that same cycle. From the next cycle, `mac_req_o` and `stall_o` stay high until `mac_done_i`. A fetch from a non-secret page raises neither.
- R4: When `mac_done_i` arrives with `mac_match_i`=1, then on the next cycle:
  - `secure_o` is 1;
  - `pc_load_o` pulses for one cycle with `pc_target_o` = start×256;
  - the valid flag is 1 for each page p with start ≤ p < start+count (capped at page 255);
  - other pages' valid flags are unchanged.
- R5: When `mac_done_i` arrives with `mac_match_i`=0, `halt_o` and `stall_o` go high on the next cycle and stay high until reset. No further MAC request or secure entry follows.
- R6: A secure-mode fetch from a non-secret page clears `secure_o` on the next cycle. The same edge clears the valid flag of every page whose secret flag is 1; non-secret pages keep theirs.
- R7: `auth_cmd_i` while secure is rejected with a one-cycle `auth_reject_o` pulse on the next cycle and starts nothing. While non-secure and idle, it starts the same MAC check as a secret fault.
- R8: A successful check sets `sig_valid_o` and sets `seq0_len_o` to 3. `sig_clr_i` clears `sig_valid_o`. `enc_fire_o` follows `enc_req_i` only while `sig_valid_o` is 1.
- R9: Region register writes are taken only in the idle state. A write during a MAC check or a halt is dropped.
- R10: `tbl_we_i` writes `tbl_secret_i` into the secret flag of page `tbl_page_i` and leaves valid flags alone. The query port returns the flags of `query_page_i` in the same cycle.
- R11: `mac_ref_reg_o` always reads 6, the crypto register holding the reference MAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Instruction fetch present |
| fetch_addr_i | input | 16 | Fetch byte address |
| stall_o | output | 1 | Hold the core and its fetch |
| halt_o | output | 1 | Core halted after failed check |
| secure_o | output | 1 | Authenticated mode active |
| pc_load_o | output | 1 | Redirect PC this cycle |
| pc_target_o | output | 16 | PC redirect target |
| region_we_i | input | 1 | Region register write strobe |
| region_wdata_i | input | 32 | Region register write data |
| region_xfer_o | output | 1 | Stored secret-transfer bit |
| region_enc_o | output | 1 | Stored encrypted-region bit |
| tbl_we_i | input | 1 | Secret flag write strobe |
| tbl_page_i | input | 8 | Page written |
| tbl_secret_i | input | 1 | Secret flag value |
| query_page_i | input | 8 | Page whose flags are read |
| query_secret_o | output | 1 | Secret flag of queried page |
| query_valid_o | output | 1 | Valid flag of queried page |
| auth_cmd_i | input | 1 | Explicit signature-authentication command |
| auth_reject_o | output | 1 | Command refused in secure mode |
| mac_req_o | output | 1 | MAC check request |
| mac_addr_o | output | 16 | Region base byte address |
| mac_len_o | output | 16 | Region length in bytes |
| mac_ref_reg_o | output | 4 | Crypto register holding reference MAC |
| mac_done_i | input | 1 | MAC check finished |
| mac_match_i | input | 1 | MAC matched |
| sig_clr_i | input | 1 | Clear saved signature |
| enc_req_i | input | 1 | Signature-based encrypt request |
| enc_fire_o | output | 1 | Encrypt request allowed |
| sig_valid_o | output | 1 | Saved signature present |
| seq0_len_o | output | 2 | Macro length loaded in sequence slot 0 |

## Verification
The bench chooses a region that runs past page 255, so a design that wrapped the page index would mark pages 0 and up valid. It also chooses a region that contains a non-secret page, which catches an exit that cleared every valid bit instead of only those on secret pages. It writes the region register in the middle of a MAC check, so a controller that failed to gate the write would move `mac_addr_o` while the engine is busy. Finally, it follows a failed check with further fetches and authentication commands: a halt that was not sticky would raise a fresh request or enter secure mode.

// File: rtl/sec_auth_pkg.sv
package sec_auth_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_HALT   = 2'd2
  } auth_st_e;

  localparam int unsigned REF_MAC_REG = 6;
  localparam int unsigned SEQ0_STEPS  = 3;
  localparam int unsigned REGION_W    = 32;
  localparam int unsigned SIZE_LSB    = 24;
  localparam int unsigned XFER_BIT    = 16;
  localparam int unsigned ENC_BIT     = 17;
endpackage

// File: rtl/sec_page_table.sv
module sec_page_table #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic              wr_secret_i,
  input  logic              set_en_i,
  input  logic [PAGE_W-1:0] set_start_i,
  input  logic [PAGE_W-1:0] set_size_i,
  input  logic              clr_en_i,
  input  logic [PAGE_W-1:0] fetch_page_i,
  output logic              fetch_secret_o,
  input  logic [PAGE_W-1:0] q_page_i,
  output logic              q_secret_o,
  output logic              q_valid_o
);
  localparam int unsigned NPAGE = 1 << PAGE_W;

  logic [NPAGE-1:0] secret_q;
  logic [NPAGE-1:0] valid_q;
  logic [PAGE_W:0]  rng_end;

  assign rng_end = {1'b0, set_start_i} + {1'b0, set_size_i};

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    localparam logic [PAGE_W:0] IDX = (PAGE_W + 1)'(p);
    logic in_rng;
    assign in_rng = (IDX >= {1'b0, set_start_i}) && (IDX < rng_end);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        secret_q[p] <= 1'b0;
      end else if (wr_en_i && (wr_page_i == IDX[PAGE_W-1:0])) begin
        secret_q[p] <= wr_secret_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[p] <= 1'b0;
      end else if (set_en_i && in_rng) begin
        valid_q[p] <= 1'b1;
      end else if (clr_en_i && secret_q[p]) begin
        valid_q[p] <= 1'b0;
      end
    end
  end

  assign fetch_secret_o = secret_q[fetch_page_i];
  assign q_secret_o     = secret_q[q_page_i];
  assign q_valid_o      = valid_q[q_page_i];

  // R4/R6: range set and secret-page clear never collide
  a_r6_set_clr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_en_i && clr_en_i));
endmodule

// File: rtl/sec_auth_fsm.sv
module sec_auth_fsm
  import sec_auth_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_valid_i,
  input  logic fetch_secret_i,
  input  logic auth_cmd_i,
  input  logic mac_done_i,
  input  logic mac_match_i,
  output logic idle_o,
  output logic stall_o,
  output logic halt_o,
  output logic secure_o,
  output logic mac_req_o,
  output logic success_o,
  output logic exit_o,
  output logic reject_o
);
  auth_st_e st_q, st_d;
  logic     secure_q, reject_q;
  logic     fault, start, fail;

  assign idle_o    = (st_q == ST_IDLE);
  assign fault     = idle_o && !secure_q && fetch_valid_i && fetch_secret_i;
  assign start     = fault || (idle_o && !secure_q && auth_cmd_i);
  assign success_o = (st_q == ST_VERIFY) && mac_done_i && mac_match_i;
  assign fail      = (st_q == ST_VERIFY) && mac_done_i && !mac_match_i;
  assign exit_o    = idle_o && secure_q && fetch_valid_i && !fetch_secret_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start) st_d = ST_VERIFY;
      ST_VERIFY: if (success_o) st_d = ST_IDLE;
                 else if (fail) st_d = ST_HALT;
      default:   st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      secure_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      reject_q <= auth_cmd_i && secure_q;
      if (success_o)   secure_q <= 1'b1;
      else if (exit_o) secure_q <= 1'b0;
    end
  end

  assign stall_o   = fault || !idle_o;
  assign halt_o    = (st_q == ST_HALT);
  assign mac_req_o = (st_q == ST_VERIFY);
  assign secure_o  = secure_q;
  assign reject_o  = reject_q;

  // R5: a halt lasts until reset
  a_r5_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  // R3: MAC requests only come from non-secure mode
  a_r3_req_nonsecure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_req_o |-> !secure_o);
  // R7: a rejection follows a cycle spent in secure mode
  a_r7_reject_after_secure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $past(secure_o));
endmodule

// File: rtl/sec_sig_unit.sv
module sec_sig_unit
  import sec_auth_pkg::*;
#(
  parameter int unsigned SEQ_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             success_i,
  input  logic             sig_clr_i,
  input  logic             enc_req_i,
  output logic             enc_fire_o,
  output logic             sig_valid_o,
  output logic [SEQ_W-1:0] seq0_len_o
);
  logic             sig_q;
  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= 1'b0;
      seq_q <= '0;
    end else begin
      if (success_i) begin
        sig_q <= 1'b1;
        seq_q <= SEQ_W'(SEQ0_STEPS);
      end else if (sig_clr_i) begin
        sig_q <= 1'b0;
      end
    end
  end

  assign enc_fire_o  = enc_req_i && sig_q;
  assign sig_valid_o = sig_q;
  assign seq0_len_o  = seq_q;

  // R8: a clear without a concurrent success leaves no signature
  a_r8_clr_drops_sig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_clr_i && !success_i) |=> !sig_valid_o);
endmodule

// File: rtl/sec_auth_ctrl.sv
module sec_auth_ctrl
  import sec_auth_pkg::*;
#(
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned PAGE_SHIFT = 8,
  parameter int unsigned SEQ_W      = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fetch_valid_i,
  input  logic [PAGE_W+PAGE_SHIFT-1:0] fetch_addr_i,
  output logic                         stall_o,
  output logic                         halt_o,
  output logic                         secure_o,
  output logic                         pc_load_o,
  output logic [PAGE_W+PAGE_SHIFT-1:0] pc_target_o,
  input  logic                         region_we_i,
  input  logic [31:0]                  region_wdata_i,
  output logic                         region_xfer_o,
  output logic                         region_enc_o,
  input  logic                         tbl_we_i,
  input  logic [PAGE_W-1:0]            tbl_page_i,
  input  logic                         tbl_secret_i,
  input  logic [PAGE_W-1:0]            query_page_i,
  output logic                         query_secret_o,
  output logic                         query_valid_o,
  input  logic                         auth_cmd_i,
  output logic                         auth_reject_o,
  output logic                         mac_req_o,
  output logic [PAGE_W+PAGE_SHIFT-1:0] mac_addr_o,
  output logic [PAGE_W+PAGE_SHIFT-1:0] mac_len_o,
  output logic [3:0]                   mac_ref_reg_o,
  input  logic                         mac_done_i,
  input  logic                         mac_match_i,
  input  logic                         sig_clr_i,
  input  logic                         enc_req_i,
  output logic                         enc_fire_o,
  output logic                         sig_valid_o,
  output logic [SEQ_W-1:0]             seq0_len_o
);
  localparam int unsigned ADDR_W = PAGE_W + PAGE_SHIFT;

  logic [REGION_W-1:0] region_q;
  logic [PAGE_W-1:0]   reg_start, reg_size, fetch_page;
  logic                fetch_secret, idle, success, exit_sec;
  logic                pc_load_q;
  logic [ADDR_W-1:0]   pc_target_q;

  assign reg_start  = region_q[PAGE_W-1:0];
  assign reg_size   = region_q[SIZE_LSB +: PAGE_W];
  assign fetch_page = fetch_addr_i[ADDR_W-1 -: PAGE_W];

  sec_page_table #(.PAGE_W(PAGE_W)) u_table (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (tbl_we_i),
    .wr_page_i     (tbl_page_i),
    .wr_secret_i   (tbl_secret_i),
    .set_en_i      (success),
    .set_start_i   (reg_start),
    .set_size_i    (reg_size),
    .clr_en_i      (exit_sec),
    .fetch_page_i  (fetch_page),
    .fetch_secret_o(fetch_secret),
    .q_page_i      (query_page_i),
    .q_secret_o    (query_secret_o),
    .q_valid_o     (query_valid_o)
  );

  sec_auth_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid_i),
    .fetch_secret_i(fetch_secret),
    .auth_cmd_i    (auth_cmd_i),
    .mac_done_i    (mac_done_i),
    .mac_match_i   (mac_match_i),
    .idle_o        (idle),
    .stall_o       (stall_o),
    .halt_o        (halt_o),
    .secure_o      (secure_o),
    .mac_req_o     (mac_req_o),
    .success_o     (success),
    .exit_o        (exit_sec),
    .reject_o      (auth_reject_o)
  );

  sec_sig_unit #(.SEQ_W(SEQ_W)) u_sig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .success_i  (success),
    .sig_clr_i  (sig_clr_i),
    .enc_req_i  (enc_req_i),
    .enc_fire_o (enc_fire_o),
    .sig_valid_o(sig_valid_o),
    .seq0_len_o (seq0_len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q    <= '0;
      pc_load_q   <= 1'b0;
      pc_target_q <= '0;
    end else begin
      if (region_we_i && idle) region_q <= region_wdata_i;
      pc_load_q <= success;
      if (success) pc_target_q <= {reg_start, {PAGE_SHIFT{1'b0}}};
    end
  end

  assign pc_load_o     = pc_load_q;
  assign pc_target_o   = pc_target_q;
  assign mac_addr_o    = {reg_start, {PAGE_SHIFT{1'b0}}};
  assign mac_len_o     = {reg_size, {PAGE_SHIFT{1'b0}}};
  assign mac_ref_reg_o = 4'(REF_MAC_REG);
  assign region_xfer_o = region_q[XFER_BIT];
  assign region_enc_o  = region_q[ENC_BIT];

  // R4: redirect is a single-cycle pulse
  a_r4_pc_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);
  // R4: secure entry coincides with the PC redirect
  a_r4_entry_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(secure_o) |-> pc_load_o);
  // R9: region stays put while the engine works
  a_r9_region_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_req_o && $past(mac_req_o)) |-> $stable(mac_addr_o));
endmodule

// File: tb/sec_auth_ctrl_bench.sv
module sec_auth_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 0;
  logic [15:0] fetch_addr = '0;
  logic        region_we = 0;
  logic [31:0] region_wdata = '0;
  logic        tbl_we = 0;
  logic [7:0]  tbl_page = '0;
  logic        tbl_secret = 0;
  logic [7:0]  query_page = '0;
  logic        auth_cmd = 0, mac_done = 0, mac_match = 0;
  logic        sig_clr = 0, enc_req = 0;
  logic        stall, halt, secure, pc_load, region_xfer, region_enc;
  logic        query_secret, query_valid, auth_reject, mac_req, enc_fire, sig_valid;
  logic [15:0] pc_target, mac_addr, mac_len;
  logic [3:0]  mac_ref_reg;
  logic [1:0]  seq0_len;

  sec_auth_ctrl u_sec_auth_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
    .stall_o(stall), .halt_o(halt), .secure_o(secure),
    .pc_load_o(pc_load), .pc_target_o(pc_target),
    .region_we_i(region_we), .region_wdata_i(region_wdata),
    .region_xfer_o(region_xfer), .region_enc_o(region_enc),
    .tbl_we_i(tbl_we), .tbl_page_i(tbl_page), .tbl_secret_i(tbl_secret),
    .query_page_i(query_page), .query_secret_o(query_secret), .query_valid_o(query_valid),
    .auth_cmd_i(auth_cmd), .auth_reject_o(auth_reject),
    .mac_req_o(mac_req), .mac_addr_o(mac_addr), .mac_len_o(mac_len),
    .mac_ref_reg_o(mac_ref_reg), .mac_done_i(mac_done), .mac_match_i(mac_match),
    .sig_clr_i(sig_clr), .enc_req_i(enc_req), .enc_fire_o(enc_fire),
    .sig_valid_o(sig_valid), .seq0_len_o(seq0_len)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done_flag = 0;

  // behavioural reference model
  bit m_secret[256];
  bit m_valid[256];
  int m_mode = 0;             // 0 idle, 1 checking, 2 halted
  bit m_secure = 0, m_pcload = 0, m_reject = 0, m_sig = 0;
  int m_pctgt = 0, m_seq = 0;
  logic [31:0] m_region = '0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit e_fault();
    return m_mode == 0 && !m_secure && fetch_valid && m_secret[fetch_addr[15:8]];
  endfunction

  task automatic compare();
    chk("R3 stall", stall, int'(e_fault() || m_mode != 0));
    chk("R5 halt", halt, int'(m_mode == 2));
    chk("R3 mac_req", mac_req, int'(m_mode == 1));
    chk("R4 secure", secure, m_secure);
    chk("R4 pc_load", pc_load, m_pcload);
    chk("R4 pc_target", pc_target, m_pctgt);
    chk("R2 mac_addr", mac_addr, int'(m_region[7:0]) * 256);
    chk("R2 mac_len", mac_len, int'(m_region[31:24]) * 256);
    chk("R2 xfer", region_xfer, m_region[16]);
    chk("R2 enc", region_enc, m_region[17]);
    chk("R10 q_secret", query_secret, m_secret[query_page]);
    chk("R4/R6 q_valid", query_valid, m_valid[query_page]);
    chk("R7 reject", auth_reject, m_reject);
    chk("R8 sig", sig_valid, m_sig);
    chk("R8 seq0", seq0_len, m_seq);
    chk("R8 enc_fire", enc_fire, int'(enc_req && m_sig));
    chk("R11 ref_reg", mac_ref_reg, 6);
  endtask

  task automatic update();
    bit succ, fl, ex, st;
    bit old_sec[256];
    int s, n;
    succ = m_mode == 1 && mac_done && mac_match;
    fl   = m_mode == 1 && mac_done && !mac_match;
    ex   = m_mode == 0 && m_secure && fetch_valid && !m_secret[fetch_addr[15:8]];
    st   = e_fault() || (m_mode == 0 && !m_secure && auth_cmd);
    old_sec = m_secret;
    s = m_region[7:0];
    n = m_region[31:24];
    m_reject = auth_cmd && m_secure;
    m_pcload = succ;
    if (succ) begin
      for (int p = s; p < s + n && p < 256; p++) m_valid[p] = 1;
      m_secure = 1; m_pctgt = s * 256; m_sig = 1; m_seq = 3; m_mode = 0;
    end else if (sig_clr) m_sig = 0;
    if (fl) m_mode = 2;
    if (ex) begin
      m_secure = 0;
      for (int p = 0; p < 256; p++) if (old_sec[p]) m_valid[p] = 0;
    end
    if (region_we && m_mode == 0 && !succ && !fl) m_region = region_wdata;
    if (tbl_we) m_secret[tbl_page] = tbl_secret;
    if (st && !succ && !fl && m_mode == 0) m_mode = 1;
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) compare();
    @(posedge clk);
    if (rst_n) update();
    #1;
  endtask

  task automatic mac_reply(input int waits, input bit ok);
    for (int i = 0; i < waits; i++) cyc();
    mac_done = 1; mac_match = ok;
    cyc();
    mac_done = 0; mac_match = 0;
  endtask

  task automatic scan(input int lo, input int hi);
    for (int p = lo; p <= hi; p++) begin
      query_page = 8'(p);
      cyc();
    end
  endtask

  task automatic mark(input int pg, input bit v);
    tbl_we = 1; tbl_page = 8'(pg); tbl_secret = v;
    cyc();
    tbl_we = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 256; p++) begin m_secret[p] = 0; m_valid[p] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state over a page sweep
    scan(0, 7);
    // R10: secret flags; R2: region with unused bits and export bits set
    mark(8'h10, 1); mark(8'h11, 1); mark(8'h12, 1); mark(8'h13, 1); mark(8'h30, 1);
    mark(8'hFF, 1);
    region_we = 1; region_wdata = 32'h0503_AB10; cyc(); region_we = 0;
    scan(8'h0F, 8'h15);
    // R3: non-secret fetch does nothing
    fetch_valid = 1; fetch_addr = 16'h0540; cyc(); cyc();
    // R3: secret fetch faults, fetch held during check
    fetch_addr = 16'h1180; cyc();
    mac_reply(3, 1);
    // R4: redirect cycle and valid range (0x10..0x14 incl. non-secret 0x14)
    cyc();
    fetch_addr = 16'h1204; cyc();
    fetch_valid = 0;
    scan(8'h0E, 8'h16);
    // R7: command in secure mode is rejected
    auth_cmd = 1; cyc(); auth_cmd = 0; cyc(); cyc();
    // R8: encrypt gated by signature
    enc_req = 1; cyc(); sig_clr = 1; cyc(); sig_clr = 0; cyc(); enc_req = 0; cyc();
    // R6: exit on non-secret fetch
    fetch_valid = 1; fetch_addr = 16'h0500; cyc(); fetch_valid = 0;
    scan(8'h0F, 8'h15);
    // R7: command in non-secure starts check; R9: region write during check dropped
    region_we = 1; region_wdata = 32'h0400_00FE; cyc(); region_we = 0;
    auth_cmd = 1; cyc(); auth_cmd = 0;
    region_we = 1; region_wdata = 32'h0200_0040; cyc(); region_we = 0;
    mac_reply(2, 1);
    // R4: range capped at page 255, no wrap to page 0
    scan(8'hFC, 8'hFF);
    scan(0, 2);
    fetch_valid = 1; fetch_addr = 16'h0700; cyc(); fetch_valid = 0;
    scan(8'hFE, 8'hFF);
    // R5: failed check halts for good
    fetch_valid = 1; fetch_addr = 16'h3000; cyc();
    mac_reply(1, 0);
    fetch_addr = 16'h1100; cyc();
    auth_cmd = 1; cyc(); auth_cmd = 0;
    region_we = 1; region_wdata = 32'h0100_0020; cyc(); region_we = 0;
    fetch_valid = 0;
    repeat (5) cyc();
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule